// File: doc/BRIEF.md
# Cascaded Display Sync Generator

This block produces raster timing from a bank of six small counters. Counter 0 is the base tick and advances on every pixel-clock enable. Each of the counters 1 to 5 is a generic unit with its own settings: a run length, the event that steps it, a start delay, a repeat limit, the event that clears it, and a rise/fall band that can drive a pin. A counter steps on the pixel tick or on the wrap event of a lower-numbered counter. Chaining counters this way builds a line event, the horizontal and vertical sync pins, and the active-line and active-pixel enables that tell a pixel fetcher when to deliver data.

Settings are loaded through a narrow write port while the global run input is low. Raising run starts every counter together from its initial state. In the intended setup, counter 1 marks each line. Counter 2 draws horizontal sync and counter 3 draws vertical sync from line events. Counter 4 is the active-line window, which is cleared by every vertical wrap. Counter 5 is the active-pixel window, which is cleared by every line event.

Top module: `disp_sync_gen`

## Requirements
- R1: A write with `cfg_we_i` high and `run_i` low stores `cfg_data_i` into field `cfg_fld_i` of counter `cfg_ctr_i` (1..5). Field codes: 0 run length, 1 step source, 2 start delay, 3 repeat limit, 4 clear source, 5 rise position, 6 fall position. Writes made while `run_i` is high, or aimed at counter 0, have no effect.
- R2: While `run_i` is low, every counter is held in its initial state and all outputs are low. The first cycle with `run_i` high begins from that state, at position zero.
- R3: Source codes: 0 means none, and k+1 selects the event of counter k, where code 1 is the pixel tick (counter 0). A code that names the counter itself or a higher counter acts as none. A counter fires its event on a step taken at position run length − 1, then returns to position 0.
- R4: A counter with a nonzero start delay D first absorbs D steps and only then counts. Its window is closed during that wait.
- R5: A repeat limit of 0 runs the counter forever. A limit N > 0 stops the counter, with its window closed and no events, after N wraps, until its clear source fires.
- R6: The clear source's event returns the counter to its initial state, including the start-delay wait. Clear takes precedence over a step in the same cycle, and no event fires then.
- R7: A counter's pin is high while it counts and 2·position ≥ rise and 2·position < fall, so positions are in half-pixel units. Rise equal to fall gives no pin activity.
- R8: `line_evt_o` is the event of counter 1, `hsync_o` is the pin of counter 2, `vsync_o` is the pin of counter 3, and `line_act_o` is the counting window of counter 4.
- R9: `pix_act_o` is a register that loads (counter 4 window AND counter 5 window) on each cycle with `pix_tick_i` and `run_i` high. It holds on other cycles and clears while `run_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Global enable; configuration is frozen while high |
| pix_tick_i | input | 1 | Pixel-clock enable (counter 0 event) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ctr_i | input | 3 | Target counter index |
| cfg_fld_i | input | 3 | Target field code |
| cfg_data_i | input | 12 | Field value |
| line_evt_o | output | 1 | Internal line event |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| line_act_o | output | 1 | Active-line enable |
| pix_act_o | output | 1 | Registered active-pixel enable |

## Verification
The hardest case to reach from the ports is the frame boundary. There, counter 3's wrap clears counter 4 in the same cycle that counter 1's line event also steps it, so the clear-over-step priority and the renewed start delay can both be seen only at the end of a full frame. The bench programs a small raster (12 pixels by 8 lines) so that the stimulus crosses two whole frame boundaries. It compares every output on every cycle against closed-form line and pixel arithmetic. The same raster is then replayed with a sparse pixel tick to separate tick cycles from idle cycles.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  parameter int CW      = 12;
  parameter int NUM_CTR = 6;

  localparam int SRC_W = $clog2(NUM_CTR + 1);
  localparam int IDX_W = $clog2(NUM_CTR);
  localparam int FLD_W = 3;

  typedef enum logic [FLD_W-1:0] {
    FLD_PERIOD = 3'd0,
    FLD_STEP   = 3'd1,
    FLD_DELAY  = 3'd2,
    FLD_REPEAT = 3'd3,
    FLD_CLEAR  = 3'd4,
    FLD_RISE   = 3'd5,
    FLD_FALL   = 3'd6
  } fld_e;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  typedef struct packed {
    logic [CW-1:0]    period;
    logic [CW-1:0]    delay;
    logic [CW-1:0]    repeats;
    logic [CW-1:0]    rise_pos;
    logic [CW-1:0]    fall_pos;
    logic [SRC_W-1:0] step_src;
    logic [SRC_W-1:0] clr_src;
  } ctr_cfg_t;

  localparam int CFG_W = $bits(ctr_cfg_t);

  // true when the next step wraps the counter; a zero length wraps every step
  function automatic logic at_last(input logic [CW-1:0] pos,
                                   input logic [CW-1:0] len);
    return ({1'b0, pos} + (CW+1)'(1)) >= {1'b0, len};
  endfunction

  // true when an incremented tally reaches a nonzero limit
  function automatic logic hits_limit(input logic [CW-1:0] cnt,
                                      input logic [CW-1:0] limit);
    return (limit != '0) && (({1'b0, cnt} + (CW+1)'(1)) == {1'b0, limit});
  endfunction

  // pin band in half-pixel units
  function automatic logic in_band(input logic [CW-1:0] pos,
                                   input logic [CW-1:0] rise,
                                   input logic [CW-1:0] fall);
    logic [CW:0] twice;
    twice = {pos, 1'b0};
    return (rise != fall) && (twice >= {1'b0, rise}) && (twice < {1'b0, fall});
  endfunction
endpackage

// File: rtl/dsg_cfg_regs.sv
module dsg_cfg_regs
  import dsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] ctr_i,
  input  logic [FLD_W-1:0] fld_i,
  input  logic [CW-1:0]    data_i,
  output ctr_cfg_t         cfg_o [1:NUM_CTR-1]
);
  for (genvar i = 1; i < NUM_CTR; i++) begin : g_bank
    ctr_cfg_t q;
    logic     hit;

    // R1: writes land only while stopped
    assign hit = we_i && !run_i && (ctr_i == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        case (fld_i)
          FLD_PERIOD: q.period   <= data_i;
          FLD_STEP:   q.step_src <= data_i[SRC_W-1:0];
          FLD_DELAY:  q.delay    <= data_i;
          FLD_REPEAT: q.repeats  <= data_i;
          FLD_CLEAR:  q.clr_src  <= data_i[SRC_W-1:0];
          FLD_RISE:   q.rise_pos <= data_i;
          FLD_FALL:   q.fall_pos <= data_i;
          default:    ;
        endcase
      end
    end

    assign cfg_o[i] = q;
  end
endmodule

// File: rtl/dsg_counter.sv
module dsg_counter
  import dsg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] delay_i,
  input  logic [CW-1:0] repeats_i,
  input  logic [CW-1:0] rise_i,
  input  logic [CW-1:0] fall_i,
  input  logic          step_i,
  input  logic          clr_i,
  output logic          ev_o,
  output logic          win_o,
  output logic          pin_o
);
  phase_e        ph_q, ph_d, start_ph;
  logic [CW-1:0] pos_q, pos_d;
  logic [CW-1:0] wait_q, wait_d;
  logic [CW-1:0] wrap_q, wrap_d;
  logic          wraps;

  assign start_ph = (delay_i == '0) ? PH_RUN : PH_WAIT;
  assign wraps    = at_last(pos_q, period_i);

  // R3/R6: event on a wrapping step, suppressed by a simultaneous clear
  assign ev_o  = run_i && step_i && !clr_i && (ph_q == PH_RUN) && wraps;
  assign win_o = run_i && (ph_q == PH_RUN);
  assign pin_o = win_o && in_band(pos_q, rise_i, fall_i);

  always_comb begin
    ph_d   = ph_q;
    pos_d  = pos_q;
    wait_d = wait_q;
    wrap_d = wrap_q;
    if (!run_i || clr_i) begin
      ph_d   = start_ph;
      pos_d  = '0;
      wait_d = '0;
      wrap_d = '0;
    end else if (step_i) begin
      case (ph_q)
        PH_WAIT: begin
          if (hits_limit(wait_q, delay_i)) begin
            ph_d  = PH_RUN;
            pos_d = '0;
          end else begin
            wait_d = wait_q + CW'(1);
          end
        end
        PH_RUN: begin
          if (wraps) begin
            pos_d = '0;
            if (hits_limit(wrap_q, repeats_i)) ph_d = PH_DONE;
            else wrap_d = wrap_q + CW'(1);
          end else begin
            pos_d = pos_q + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_WAIT;
      pos_q  <= '0;
      wait_q <= '0;
      wrap_q <= '0;
    end else begin
      ph_q   <= ph_d;
      pos_q  <= pos_d;
      wait_q <= wait_d;
      wrap_q <= wrap_d;
    end
  end
endmodule

// File: rtl/dsg_pix_gate.sv
module dsg_pix_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  input  logic line_win_i,
  input  logic pix_win_i,
  output logic act_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_o <= 1'b0;
    else if (!run_i)  act_o <= 1'b0;
    else if (tick_i)  act_o <= line_win_i && pix_win_i;
  end
endmodule

// File: rtl/disp_sync_gen.sv
module disp_sync_gen
  import dsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             pix_tick_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_ctr_i,
  input  logic [FLD_W-1:0] cfg_fld_i,
  input  logic [CW-1:0]    cfg_data_i,
  output logic             line_evt_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             line_act_o,
  output logic             pix_act_o
);
  localparam int LINE_CTR = 1;
  localparam int HS_CTR   = 2;
  localparam int VS_CTR   = 3;
  localparam int VACT_CTR = 4;
  localparam int HACT_CTR = 5;

  ctr_cfg_t cfg [1:NUM_CTR-1];
  logic     base_tick;
  logic [NUM_CTR-1:0]           ev_vec;
  logic [(NUM_CTR-1)*CFG_W-1:0] cfg_bits;

  assign base_tick = pix_tick_i && run_i;
  assign ev_vec[0] = base_tick;

  dsg_cfg_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_i),
    .we_i   (cfg_we_i),
    .ctr_i  (cfg_ctr_i),
    .fld_i  (cfg_fld_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg)
  );

  for (genvar i = 1; i < NUM_CTR; i++) begin : g_ctr
    logic [i-1:0] lower_ev;
    logic         step, clr, ev, win, pin;

    for (genvar j = 0; j < i; j++) begin : g_lower
      if (j == 0) begin : g_base
        assign lower_ev[j] = base_tick;
      end else begin : g_chain
        assign lower_ev[j] = g_ctr[j].ev;
      end
    end

    // R3: only lower counters are selectable
    always_comb begin
      step = 1'b0;
      clr  = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (cfg[i].step_src == SRC_W'(j + 1)) step = lower_ev[j];
        if (cfg[i].clr_src  == SRC_W'(j + 1)) clr  = lower_ev[j];
      end
    end

    dsg_counter u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_i),
      .period_i  (cfg[i].period),
      .delay_i   (cfg[i].delay),
      .repeats_i (cfg[i].repeats),
      .rise_i    (cfg[i].rise_pos),
      .fall_i    (cfg[i].fall_pos),
      .step_i    (step),
      .clr_i     (clr),
      .ev_o      (ev),
      .win_o     (win),
      .pin_o     (pin)
    );

    assign ev_vec[i] = ev;
    assign cfg_bits[(i-1)*CFG_W +: CFG_W] = cfg[i];
  end

  assign line_evt_o = g_ctr[LINE_CTR].ev;
  assign hsync_o    = g_ctr[HS_CTR].pin;
  assign vsync_o    = g_ctr[VS_CTR].pin;
  assign line_act_o = g_ctr[VACT_CTR].win;

  dsg_pix_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .tick_i     (pix_tick_i),
    .line_win_i (g_ctr[VACT_CTR].win),
    .pix_win_i  (g_ctr[HACT_CTR].win),
    .act_o      (pix_act_o)
  );
endmodule

// File: rtl/dsg_checker.sv
module dsg_checker
  import dsg_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           run_i,
  input logic                           pix_tick_i,
  input logic                           line_evt_o,
  input logic                           hsync_o,
  input logic                           vsync_o,
  input logic                           line_act_o,
  input logic                           pix_act_o,
  input logic [NUM_CTR-1:0]             ev_vec,
  input logic [(NUM_CTR-1)*CFG_W-1:0]   cfg_bits
);
  assert_quiet_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> (ev_vec[NUM_CTR-1:1] == '0 && !hsync_o && !vsync_o && !line_act_o));

  assert_pix_cleared_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !pix_act_o);

  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i)) |-> $stable(cfg_bits));

  assert_line_evt_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt_o |-> (pix_tick_i && run_i));

  assert_vsync_follows_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && !$stable(vsync_o)) |-> $past(line_evt_o));

  assert_hsync_follows_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && !$stable(hsync_o)) |-> $past(pix_tick_i));

  assert_pix_act_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !pix_tick_i) |=> (!run_i || $stable(pix_act_o)));

  assert_pix_act_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_act_o) |-> $past(line_act_o && pix_tick_i));
endmodule

bind disp_sync_gen dsg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_i      (run_i),
  .pix_tick_i (pix_tick_i),
  .line_evt_o (line_evt_o),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .line_act_o (line_act_o),
  .pix_act_o  (pix_act_o),
  .ev_vec     (ev_vec),
  .cfg_bits   (cfg_bits)
);

// File: tb/disp_sync_gen_test.sv
`timescale 1ns/1ps
module disp_sync_gen_test;
  localparam int HT   = 12;  // pixels per line
  localparam int VT   = 8;   // lines per frame
  localparam int HDLY = 1;   // hsync start delay
  localparam int HSW  = 3;   // hsync width in pixels
  localparam int VSS  = 1;   // vsync first line
  localparam int VSW  = 2;   // vsync width in lines
  localparam int VOFF = 2;   // first active line
  localparam int VH   = 4;   // active lines
  localparam int HOFF = 3;   // first active pixel
  localparam int HW   = 5;   // active pixels

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic        pix_tick_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_ctr_i = '0;
  logic [2:0]  cfg_fld_i = '0;
  logic [11:0] cfg_data_i = '0;
  logic        line_evt_o, hsync_o, vsync_o, line_act_o, pix_act_o;

  int checks = 0;
  int errors = 0;
  int n = 0;  // pixel ticks consumed since run rose

  always #4 clk = ~clk;

  disp_sync_gen uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .pix_tick_i (pix_tick_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_ctr_i  (cfg_ctr_i),
    .cfg_fld_i  (cfg_fld_i),
    .cfg_data_i (cfg_data_i),
    .line_evt_o (line_evt_o),
    .hsync_o    (hsync_o),
    .vsync_o    (vsync_o),
    .line_act_o (line_act_o),
    .pix_act_o  (pix_act_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at tick %0d: actual %b expected %b", req, what, n, act, exp);
    end
  endtask

  // closed-form raster arithmetic
  function automatic logic m_line_act(input int t);
    int y = (t / HT) % VT;
    return (y >= VOFF) && (y < VOFF + VH);
  endfunction
  function automatic logic m_pix_win(input int t);
    int x = t % HT;
    return (x >= HOFF) && (x < HOFF + HW);
  endfunction
  function automatic logic m_hsync(input int t);
    return (t >= HDLY) && (((t - HDLY) % HT) < HSW);
  endfunction
  function automatic logic m_vsync(input int t);
    int y = (t / HT) % VT;
    return (y >= VSS) && (y < VSS + VSW);
  endfunction

  task automatic cfg_wr(input int ctr, input int fld, input int val);
    @(negedge clk);
    pix_tick_i = 1'b0;
    cfg_we_i   = 1'b1;
    cfg_ctr_i  = 3'(ctr);
    cfg_fld_i  = 3'(fld);
    cfg_data_i = 12'(val);
    @(negedge clk);
    cfg_we_i   = 1'b0;
  endtask

  task automatic program_raster();
    cfg_wr(1, 0, HT);  cfg_wr(1, 1, 1);
    cfg_wr(2, 0, HT);  cfg_wr(2, 1, 1);  cfg_wr(2, 2, HDLY);
    cfg_wr(2, 5, 0);   cfg_wr(2, 6, 2*HSW);
    cfg_wr(3, 0, VT);  cfg_wr(3, 1, 2);
    cfg_wr(3, 5, 2*VSS); cfg_wr(3, 6, 2*(VSS+VSW));
    cfg_wr(4, 0, 1);   cfg_wr(4, 1, 2);  cfg_wr(4, 2, VOFF);
    cfg_wr(4, 3, VH);  cfg_wr(4, 4, 4);
    cfg_wr(5, 0, 1);   cfg_wr(5, 1, 1);  cfg_wr(5, 2, HOFF);
    cfg_wr(5, 3, HW);  cfg_wr(5, 4, 2);
  endtask

  task automatic stop_and_check();
    @(negedge clk);
    run_i = 1'b0;
    pix_tick_i = 1'b1;
    @(negedge clk);
    #1;
    chk("R2", "line_evt stopped", line_evt_o, 1'b0);
    chk("R2", "hsync stopped", hsync_o, 1'b0);
    chk("R2", "vsync stopped", vsync_o, 1'b0);
    chk("R2", "line_act stopped", line_act_o, 1'b0);
    chk("R2", "pix_act stopped", pix_act_o, 1'b0);
    pix_tick_i = 1'b0;
  endtask

  task automatic start_run();
    @(negedge clk);
    run_i = 1'b1;
    n = 0;
  endtask

  // drives cycles, ticking every 'every' cycles, and compares every output
  task automatic run_checked(input int cycles, input int every);
    for (int c = 0; c < cycles; c++) begin
      logic tk;
      tk = ((c % every) == 0);
      @(negedge clk);
      pix_tick_i = tk;
      #1;
      chk("R3/R8", "line_evt", line_evt_o, tk && ((n % HT) == HT - 1));
      chk("R4/R7", "hsync", hsync_o, m_hsync(n));
      chk("R7", "vsync", vsync_o, m_vsync(n));
      chk("R6", "line_act", line_act_o, m_line_act(n));
      chk("R9", "pix_act", pix_act_o, (n > 0) && m_line_act(n - 1) && m_pix_win(n - 1));
      @(posedge clk);
      if (tk) n++;
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R2", "line_evt in reset", line_evt_o, 1'b0);
    chk("R2", "pix_act in reset", pix_act_o, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R2", "hsync after reset", hsync_o, 1'b0);
    chk("R2", "line_act after reset", line_act_o, 1'b0);
  endtask

  task automatic t_dense_frames();
    program_raster();
    start_run();
    run_checked(2*HT*VT + 20, 1);
  endtask

  task automatic t_sparse_ticks();
    stop_and_check();
    start_run();
    run_checked(3*(HT*VT + 10), 3);
  endtask

  task automatic t_write_while_running();
    cfg_wr(1, 0, 5);   // R1: must not land
    cfg_wr(5, 2, 0);   // R1: must not land
    run_checked(3*HT, 1);
  endtask

  task automatic t_repeat_limit();
    int seen = 0;
    stop_and_check();
    cfg_wr(1, 3, 3);
    start_run();
    for (int c = 0; c < 8*HT; c++) begin
      @(negedge clk);
      pix_tick_i = 1'b1;
      #1;
      if (line_evt_o) seen++;
    end
    chk("R5", "three line events then stop", 1'(seen == 3), 1'b1);
    if (seen != 3) $display("FAIL R5 line event count actual %0d expected 3", seen);
    stop_and_check();
    cfg_wr(1, 3, 0);
  endtask

  task automatic t_self_source();
    int pa = 0;
    int la = 0;
    cfg_wr(5, 1, 6);   // R3: code names counter 5 itself -> none
    start_run();
    for (int c = 0; c < HT*VT; c++) begin
      @(negedge clk);
      pix_tick_i = 1'b1;
      #1;
      if (pix_act_o) pa++;
      if (line_act_o) la++;
    end
    chk("R3", "self-selected source never steps", 1'(pa == 0), 1'b1);
    chk("R3", "line window still opens", 1'(la > 0), 1'b1);
    stop_and_check();
    cfg_wr(5, 1, 1);
  endtask

  task automatic t_no_pin();
    int hs = 0;
    cfg_wr(2, 5, 4);
    cfg_wr(2, 6, 4);   // R7: rise equals fall
    start_run();
    for (int c = 0; c < 3*HT; c++) begin
      @(negedge clk);
      pix_tick_i = 1'b1;
      #1;
      if (hsync_o) hs++;
    end
    chk("R7", "equal rise and fall keeps pin low", 1'(hs == 0), 1'b1);
    stop_and_check();
    cfg_wr(2, 5, 0);
    cfg_wr(2, 6, 2*HSW);
    start_run();
    run_checked(HT*VT, 1);
  endtask

  initial begin
    t_reset();
    t_dense_frames();
    t_write_while_running();
    t_sparse_ticks();
    t_repeat_limit();
    t_self_source();
    t_no_pin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule